// File: doc/BRIEF.md
# System Flags Register Controller

This block keeps the processor's system flags word in a register and applies rules that depend on the operating mode to every update. Software writes a new word through a data port with a strobe. The block masks out reserved positions, and while the long-mode indicator is high it keeps the virtual-8086 bit clear. A fast system-call entry strobe saves the current word and clears the bits picked by a programmable mask. A matching return strobe restores the saved word through the same write filter.

Two combinational and registered outputs report on the word. The first flags a virtual interrupt as pending. It does so only when the virtual interrupt-enable copy and the pending bit are both set, at least one of the two virtual-interrupt enable controls is on, and the I/O privilege level is below 3. The second is a one-cycle protection-fault pulse. It fires when a return-from-interrupt is requested in long mode while the nested-task bit is set. Decoding of instructions, delivery of interrupts and handling of faults happen outside the block.

Top module: `sysflags_ctrl`

## Requirements
- R1: After reset the flags read 0x0000_0000_0000_0002, `gp_fault` is 0 and `vint_pending` is 0.
- R2: On a software write the flags take the written value on bits 0, 2, 4, 6 to 14 and 16 to 21. This includes the identification bit 21, which reads back exactly as written, set or clear. Bit 1 always reads 1. Bits 3, 5, 15 and 22 to 63 always read 0.
- R3: A write made while `long_mode` is 1 leaves bit 17 (virtual-8086) at 0 whatever the data holds. With `long_mode` at 0, bit 17 takes the written value.
- R4: Bit 14 (nested task) is set by a software write in either mode. No strobe other than a write or a return restore ever changes it from 0 to 1.
- R5: `vint_pending` is 1 exactly when flags bit 19 and bit 20 are both 1, at least one of `vx_ext_en` and `pm_vint_en` is 1, and `io_priv` is below 3. It follows these inputs in the same cycle.
- R6: When `sc_entry` is 1, the next flags equal the current flags with every bit set in `sc_mask` cleared. Two bits are exempt from the mask: bit 1, and bit 20, which stays as it was. The current flags are saved for the return.
- R7: When `sc_return` is 1, the next flags equal the saved word passed through the R2 and R3 filter for the current `long_mode`. Bit 20 keeps its current value, so only a software write ever changes bit 20.
- R8: When `iret_req` is 1 while `long_mode` is 1 and flags bit 14 is 1, `gp_fault` is 1 in the following cycle. In every other case it is 0 in the following cycle. A return-from-interrupt request never changes the flags.
- R9: When several strobes arrive in one cycle, `sc_entry` wins over `sc_return`, and `sc_return` wins over `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write value |
| long_mode | input | 1 | Long-mode indicator |
| vx_ext_en | input | 1 | Virtual-8086 extensions enable |
| pm_vint_en | input | 1 | Protected-mode virtual interrupts enable |
| io_priv | input | 2 | Current I/O privilege level |
| sc_entry | input | 1 | Fast system-call entry strobe |
| sc_mask | input | 64 | Bits to clear on system-call entry |
| sc_return | input | 1 | Fast system-call return strobe |
| iret_req | input | 1 | Return-from-interrupt request |
| flags | output | 64 | Current flags word |
| vint_pending | output | 1 | Virtual interrupt pending |
| gp_fault | output | 1 | Protection-fault pulse |

## Verification
Directed writes of all ones, a lone identification bit and all zeros separate the writable positions from the fixed ones. Writes of bit 17 with `long_mode` high and then low show whether the mode filter is active. The enable pair and privilege level are swept with bits 19 and 20 set, which exposes any term missing from the pending condition. A system-call entry with an all-ones mask followed by a return shows whether bit 1 and bit 20 are protected. Constrained random cycles then mix writes, entries, returns and interrupt returns, including strobes that collide in the same cycle, which tests the priority order and the save/restore path against a bench model.

// File: rtl/sysflags_pkg.sv
`timescale 1ns/1ps
package sysflags_pkg;
    localparam int FW      = 64;
    localparam int LOW_W   = FW / 2;

    localparam int B_FIX1  = 1;
    localparam int B_NT    = 14;
    localparam int B_VM    = 17;
    localparam int B_VIF   = 19;
    localparam int B_VIP   = 20;
    localparam int B_ID    = 21;
    localparam int TOP_LIVE = B_ID;

    localparam logic [FW-1:0] ONE = {{(FW-1){1'b0}}, 1'b1};

    // reserved positions inside the live range that read as zero
    localparam logic [FW-1:0] RSV_ZERO = (ONE << 3) | (ONE << 5) | (ONE << 15);
    // positions that hold software data
    localparam logic [FW-1:0] LIVE_MASK =
        ((ONE << (TOP_LIVE + 1)) - ONE) & ~RSV_ZERO & ~(ONE << B_FIX1);
    // positions a system-call entry may clear
    localparam logic [FW-1:0] CLR_OK = ~((ONE << B_FIX1) | (ONE << B_VIP));
    localparam logic [FW-1:0] RESET_VAL = ONE << B_FIX1;

    typedef logic [FW-1:0] word_t;

    typedef struct packed {
        word_t flags;
        word_t saved;
        logic  gp;
    } state_t;
endpackage

// File: rtl/sysflags_filter.sv
`timescale 1ns/1ps
module sysflags_filter
    import sysflags_pkg::*;
#(
    parameter int W = FW
) (
    input  logic [W-1:0] raw,
    input  logic         long_mode,
    output logic [W-1:0] clean
);
    localparam logic [W-1:0] KEEP = W'(LIVE_MASK);

    always_comb begin
        clean         = raw & KEEP;
        clean[B_FIX1] = 1'b1;
        if (long_mode) begin
            clean[B_VM] = 1'b0;
        end
    end
endmodule

// File: rtl/sysflags_entry.sv
`timescale 1ns/1ps
module sysflags_entry
    import sysflags_pkg::*;
#(
    parameter int W = FW
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    output logic [W-1:0] cleared
);
    localparam logic [W-1:0] ALLOWED = W'(CLR_OK);

    logic [W-1:0] eff_mask;

    always_comb begin
        eff_mask = mask & ALLOWED;
        cleared  = cur & ~eff_mask;
    end
endmodule

// File: rtl/sysflags_vint.sv
`timescale 1ns/1ps
module sysflags_vint
#(
    parameter int PL_W = 2
) (
    input  logic            vif,
    input  logic            vip,
    input  logic            ext_en,
    input  logic            pm_en,
    input  logic [PL_W-1:0] io_priv,
    output logic            pending
);
    localparam logic [PL_W-1:0] PL_MAX = {PL_W{1'b1}};

    logic honoured;

    always_comb begin
        honoured = (ext_en | pm_en) && (io_priv < PL_MAX);
        pending  = honoured & vif & vip;
    end
endmodule

// File: rtl/sysflags_ctrl.sv
`timescale 1ns/1ps
module sysflags_ctrl
    import sysflags_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [63:0]   wr_data,
    input  logic          long_mode,
    input  logic          vx_ext_en,
    input  logic          pm_vint_en,
    input  logic [1:0]    io_priv,
    input  logic          sc_entry,
    input  logic [63:0]   sc_mask,
    input  logic          sc_return,
    input  logic          iret_req,
    output logic [63:0]   flags,
    output logic          vint_pending,
    output logic          gp_fault
);
    state_t st_d, st_q;
    word_t  wr_val, ret_val, entry_val;

    sysflags_filter #(.W(FW)) u_wr_filt (
        .raw       (wr_data),
        .long_mode (long_mode),
        .clean     (wr_val)
    );

    sysflags_filter #(.W(FW)) u_ret_filt (
        .raw       (st_q.saved),
        .long_mode (long_mode),
        .clean     (ret_val)
    );

    sysflags_entry #(.W(FW)) u_entry (
        .cur     (st_q.flags),
        .mask    (sc_mask),
        .cleared (entry_val)
    );

    sysflags_vint #(.PL_W(2)) u_vint (
        .vif     (st_q.flags[B_VIF]),
        .vip     (st_q.flags[B_VIP]),
        .ext_en  (vx_ext_en),
        .pm_en   (pm_vint_en),
        .io_priv (io_priv),
        .pending (vint_pending)
    );

    always_comb begin
        st_d    = st_q;
        st_d.gp = iret_req & long_mode & st_q.flags[B_NT];
        if (sc_entry) begin
            st_d.saved = st_q.flags;
            st_d.flags = entry_val;
        end else if (sc_return) begin
            st_d.flags        = ret_val;
            st_d.flags[B_VIP] = st_q.flags[B_VIP];
        end else if (wr_en) begin
            st_d.flags = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= RESET_VAL;
            st_q.saved <= RESET_VAL;
            st_q.gp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags    = st_q.flags;
    assign gp_fault = st_q.gp;
endmodule

// File: rtl/sysflags_chk.sv
`timescale 1ns/1ps
module sysflags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        long_mode,
    input logic [1:0]  io_priv,
    input logic        sc_entry,
    input logic [63:0] sc_mask,
    input logic        sc_return,
    input logic        iret_req,
    input logic [63:0] flags,
    input logic        vint_pending,
    input logic        gp_fault
);
    localparam logic [63:0] CLEARABLE = ~64'h0000_0000_0010_0002;

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] && flags[63:22] == '0 && !flags[3] && !flags[5] && !flags[15]); // R2

    AST_VM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sc_entry && !sc_return && long_mode) |=> !flags[17]); // R3

    AST_NT_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sc_return) |=> !$rose(flags[14])); // R4

    AST_PRIV_BLOCKS_VINT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_priv == 2'd3) |-> !vint_pending); // R5

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_entry |=> ((flags & $past(sc_mask) & CLEARABLE) == '0)); // R6

    AST_PEND_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || sc_entry || sc_return) |=> $stable(flags[20])); // R7

    AST_GP_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_req && long_mode && flags[14]) |=> gp_fault); // R8

    AST_GP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(iret_req && long_mode && flags[14]) |=> !gp_fault); // R8

    AST_IRET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_req && !wr_en && !sc_entry && !sc_return) |=> $stable(flags)); // R8
endmodule

bind sysflags_ctrl sysflags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .long_mode    (long_mode),
    .io_priv      (io_priv),
    .sc_entry     (sc_entry),
    .sc_mask      (sc_mask),
    .sc_return    (sc_return),
    .iret_req     (iret_req),
    .flags        (flags),
    .vint_pending (vint_pending),
    .gp_fault     (gp_fault)
);

// File: tb/sim_sysflags_ctrl.sv
`timescale 1ns/1ps
module sim_sysflags_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        long_mode = 1'b0;
    logic        vx_ext_en = 1'b0;
    logic        pm_vint_en = 1'b0;
    logic [1:0]  io_priv = 2'd0;
    logic        sc_entry = 1'b0;
    logic [63:0] sc_mask = '0;
    logic        sc_return = 1'b0;
    logic        iret_req = 1'b0;
    logic [63:0] flags;
    logic        vint_pending;
    logic        gp_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_flags, m_saved;
    logic        m_gp;

    always #2.5 clk = ~clk;

    sysflags_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .long_mode(long_mode), .vx_ext_en(vx_ext_en), .pm_vint_en(pm_vint_en),
        .io_priv(io_priv), .sc_entry(sc_entry), .sc_mask(sc_mask),
        .sc_return(sc_return), .iret_req(iret_req), .flags(flags),
        .vint_pending(vint_pending), .gp_fault(gp_fault)
    );

    // writable: 0,2,4,6..14,16..21 ; bit1 forced 1 ; bit17 cleared in long mode
    function automatic logic [63:0] filt(logic [63:0] d, logic lm);
        logic [63:0] r;
        r = (d & 64'h0000_0000_003F_7FD5) | 64'h2;
        if (lm) r[17] = 1'b0;
        return r;
    endfunction

    function automatic logic exp_vint();
        return (vx_ext_en || pm_vint_en) && (io_priv != 2'd3)
               && m_flags[19] && m_flags[20];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic verify(string tag);
        check({tag, " flags"}, flags, m_flags);
        check({tag, " gp_fault"}, {63'd0, gp_fault}, {63'd0, m_gp});
        check({tag, " vint_pending"}, {63'd0, vint_pending}, {63'd0, exp_vint()});
    endtask

    task automatic cyc();
        logic [63:0] nf, ns;
        logic ng;
        nf = m_flags;
        ns = m_saved;
        ng = iret_req & long_mode & m_flags[14];
        if (sc_entry) begin
            ns = m_flags;
            nf = m_flags & ~(sc_mask & ~64'h0000_0000_0010_0002);
        end else if (sc_return) begin
            nf = filt(m_saved, long_mode);
            nf[20] = m_flags[20];
        end else if (wr_en) begin
            nf = filt(wr_data, long_mode);
        end
        @(posedge clk);
        @(negedge clk);
        m_flags = nf;
        m_saved = ns;
        m_gp = ng;
    endtask

    task automatic idle();
        wr_en = 1'b0; sc_entry = 1'b0; sc_return = 1'b0; iret_req = 1'b0;
    endtask

    task automatic wr(logic [63:0] d, logic lm);
        idle();
        wr_en = 1'b1; wr_data = d; long_mode = lm;
        cyc();
        idle();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_flags = 64'h2; m_saved = 64'h2; m_gp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset flags", flags, 64'h2);
        verify("R1");

        // R2 reserved and live bits
        wr(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check("R2 all ones", flags, 64'h0000_0000_003F_7FD7);
        wr(64'h0000_0000_0020_0000, 1'b0);
        check("R2 id set", flags, 64'h0000_0000_0020_0002);
        wr(64'h0, 1'b0);
        check("R2 id clear", flags, 64'h2);

        // R3 virtual-8086 bit
        wr(64'h0000_0000_0002_0000, 1'b1);
        check("R3 long mode blocks", flags, 64'h2);
        wr(64'h0000_0000_0002_0000, 1'b0);
        check("R3 legacy keeps", flags, 64'h0000_0000_0002_0002);

        // R4 nested task by software, R8 fault
        wr(64'h0000_0000_0000_4000, 1'b1);
        check("R4 nt write", flags, 64'h4002);
        idle(); iret_req = 1'b1; long_mode = 1'b1;
        cyc();
        check("R8 gp raised", {63'd0, gp_fault}, 64'd1);
        check("R8 flags kept", flags, 64'h4002);
        idle(); cyc();
        check("R8 gp drops", {63'd0, gp_fault}, 64'd0);
        iret_req = 1'b1; long_mode = 1'b0;
        cyc(); idle();
        check("R8 legacy no gp", {63'd0, gp_fault}, 64'd0);

        // R5 pending condition
        wr(64'h0000_0000_0018_0000, 1'b0);
        vx_ext_en = 1'b1; pm_vint_en = 1'b0; io_priv = 2'd0;
        #1 check("R5 ext on", {63'd0, vint_pending}, 64'd1);
        io_priv = 2'd3;
        #1 check("R5 priv 3", {63'd0, vint_pending}, 64'd0);
        vx_ext_en = 1'b0; io_priv = 2'd2;
        #1 check("R5 both off", {63'd0, vint_pending}, 64'd0);
        pm_vint_en = 1'b1;
        #1 check("R5 pm on", {63'd0, vint_pending}, 64'd1);
        @(negedge clk);

        // R6 entry, R7 return
        wr(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        idle(); sc_entry = 1'b1; sc_mask = '1;
        cyc(); idle();
        check("R6 entry clears", flags, 64'h0000_0000_0010_0002);
        wr(64'h0, 1'b0);
        sc_return = 1'b1; long_mode = 1'b0;
        cyc(); idle();
        check("R7 return legacy", flags, 64'h0000_0000_002F_7FD7);
        sc_return = 1'b1; long_mode = 1'b1;
        cyc(); idle();
        check("R7 return long", flags, 64'h0000_0000_002D_7FD7);

        // R9 priority
        wr(64'h0000_0000_0000_0041, 1'b0);
        sc_entry = 1'b1; sc_mask = 64'h1; sc_return = 1'b1;
        wr_en = 1'b1; wr_data = 64'h0000_0000_0020_0000;
        cyc(); idle();
        check("R9 entry wins", flags, 64'h0000_0000_0000_0042);
        sc_return = 1'b1; wr_en = 1'b1; wr_data = 64'h0;
        cyc(); idle();
        check("R9 return beats write", flags, 64'h0000_0000_0000_0043);

        // random mix: R2 R3 R5 R6 R7 R8 R9
        for (int i = 0; i < 600; i++) begin
            wr_en      = ($urandom % 2) == 0;
            wr_data    = {$urandom, $urandom};
            if (($urandom % 3) == 0) wr_data[14] = 1'b1;
            long_mode  = ($urandom % 2) == 0;
            vx_ext_en  = ($urandom % 2) == 0;
            pm_vint_en = ($urandom % 2) == 0;
            io_priv    = 2'($urandom);
            sc_entry   = ($urandom % 10) == 0;
            sc_mask    = {$urandom, $urandom};
            sc_return  = ($urandom % 10) == 0;
            iret_req   = ($urandom % 4) == 0;
            cyc();
            verify("R2 R3 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule